// File: doc/BRIEF.md
# Programmable Countdown Timer Channel

This block is one countdown timer channel with two 32-bit words of register space. Software writes a control word that arms the channel, picks auto-reload or single-shot operation and sets a 29-bit terminal count. The channel then counts down by one on every cycle in which the external tick strobe is high. When the count runs out, the channel raises a level-sensitive, active-high interrupt. That interrupt stays high until software writes a clear bit into the second word.

The terminal count is programmed one less than the wanted interval: a programmed value N gives an expiry after N+1 ticks. In auto-reload mode the channel reloads the stored value on the expiring tick and keeps running. In single-shot mode it drops its own arm bit and stops. Writing a zero control word halts the channel. Any write of the control word reloads the counter from the new value, so the next interval starts fresh.

Top module: `tmr_channel`

## Requirements
- R1: After reset, irq is 0, the channel is disarmed, and reads of both words return 0.
- R2: A write at byte offset 0x0 stores bit 31 as arm, bit 30 as auto-reload and bits 28:0 as the count. A read of offset 0x0 returns those fields in the same positions, with bit 29 reading 0. rd_data is valid one cycle after rd_addr is presented.
- R3: With programmed value N, the interrupt sets on the (N+1)-th tick strobe after the write. Cycles without a tick do not count, and a tick in the same cycle as the write is ignored.
- R4: In single-shot mode (bit 30 = 0), expiry clears the arm bit (bit 31 reads 0 afterwards) and no further expiry occurs.
- R5: In auto-reload mode (bit 30 = 1), the channel keeps its arm bit and expires again every N+1 ticks.
- R6: irq stays 1 until a write at offset 0x4 with bit 30 = 1. A write at offset 0x4 with bit 30 = 0 leaves irq unchanged.
- R7: If an expiry and a clear write fall in the same cycle, irq stays 1.
- R8: Writing 0x00000000 at offset 0x0 stops counting (no further expiry) and does not change irq.
- R9: Rewriting offset 0x0 with the arm bit set while the channel runs restarts the interval from the new value.
- R10: A read of offset 0x4 returns irq in bit 30 and 0 in all other bits. Reads of other offsets return 0.
- R11: The full 29-bit count 0x1FFFFFFF is accepted: writing 0xFFFFFFFF reads back 0xDFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count strobe, one decrement per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Byte offset of the read |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, active high |

## Verification
The bench targets the off-by-one of the N+1 count. A design that expired after N ticks would fire too early for N=0, and that case is run directly. It also checks irregular tick strobes, which catch a design that counts cycles instead of ticks. An expiry is made to land on the same edge as a clear, so a design that gave the clear priority would drop the interrupt. The bench rewrites the control word mid-interval and then writes all zeros, which exposes a design that keeps its old count or that clears the flag on a stop. The auto-reload period is measured between two expiries, which catches a reload from zero or an extra idle tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned VAL_OFS = 0;
  localparam int unsigned IRQ_OFS = 4;
  localparam int unsigned ARM_BIT = 31;
  localparam int unsigned AUTO_BIT = 30;
  localparam int unsigned CLR_BIT = 30;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 29
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              expire,
  input  logic              irq,
  output logic              load,
  output logic              clr,
  output logic              arm_q,
  output logic              auto_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] A_VAL = ADDR_W'(VAL_OFS);
  localparam logic [ADDR_W-1:0] A_IRQ = ADDR_W'(IRQ_OFS);

  logic [DATA_W-1:0] rd_next;

  assign load = wr_en && (wr_addr == A_VAL);
  assign clr  = wr_en && (wr_addr == A_IRQ) && wr_data[CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q    <= 1'b0;
      auto_q   <= 1'b0;
      reload_q <= '0;
    end else if (load) begin
      arm_q    <= wr_data[ARM_BIT];
      auto_q   <= wr_data[AUTO_BIT];
      reload_q <= wr_data[CNT_W-1:0];
    end else if (expire && !auto_q) begin
      arm_q <= 1'b0;
    end
  end

  always_comb begin
    rd_next = '0;
    if (rd_addr == A_VAL) begin
      rd_next[CNT_W-1:0] = reload_q;
      rd_next[ARM_BIT]   = arm_q;
      rd_next[AUTO_BIT]  = auto_q;
    end else if (rd_addr == A_IRQ) begin
      rd_next[CLR_BIT] = irq;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             auto_mode,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  output logic             expire,
  output logic [CNT_W-1:0] cnt_q
);
  logic at_zero;

  assign at_zero = (cnt_q == '0);
  assign expire  = run && tick && !load && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && tick) begin
      if (!at_zero)       cnt_q <= cnt_q - 1'b1;
      else if (auto_mode) cnt_q <= reload;
    end
  end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)         irq <= 1'b0;
    else if (expire) irq <= 1'b1;
    else if (clr)    irq <= 1'b0;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 29
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic             load_pulse;
  logic             clr_pulse;
  logic             arm_q;
  logic             auto_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic             expire;

  tmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .expire(expire), .irq(irq), .load(load_pulse),
    .clr(clr_pulse), .arm_q(arm_q), .auto_q(auto_q), .reload_q(reload_q),
    .rd_data(rd_data)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .run(arm_q), .auto_mode(auto_q),
    .load(load_pulse), .load_val(wr_data[CNT_W-1:0]), .reload(reload_q),
    .expire(expire), .cnt_q(cnt_q)
  );

  tmr_irq u_irq (
    .clk(clk), .rst(rst), .expire(expire), .clr(clr_pulse), .irq(irq)
  );
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int CNT_W = 29
) (
  input logic             clk,
  input logic             rst,
  input logic             expire,
  input logic             irq,
  input logic             arm,
  input logic             auto_mode,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic             clr,
  input logic             load
);
  AST_EXPIRE_SETS_IRQ: assert property (@(posedge clk) disable iff (rst)
    expire |=> irq); // R3
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr) |=> irq); // R6
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (clr && !expire) |=> !irq); // R6
  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (rst)
    (expire && !auto_mode) |=> !arm); // R4
  AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (expire && auto_mode) |=> (arm && cnt == $past(reload))); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!arm && !load) |=> $stable(cnt)); // R8
  AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (expire && clr) |=> irq); // R7
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .expire(expire), .irq(irq), .arm(arm_q),
  .auto_mode(auto_q), .cnt(cnt_q), .reload(reload_q), .clr(clr_pulse),
  .load(load_pulse)
);

// File: tb/tb_tmr_channel.sv
`timescale 1ns/1ps
module tb_tmr_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  tmr_channel dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // behavioural model: ticks remaining until expiry
  bit          m_arm, m_auto, m_irq;
  int unsigned m_reload;
  longint      m_left;
  logic [31:0] m_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_arm = 0; m_auto = 0; m_irq = 0; m_reload = 0; m_left = 1; m_rd = '0;
    end else begin
      bit fired;
      if (rd_addr == 3'd0)      m_rd = {m_arm, m_auto, 1'b0, m_reload[28:0]};
      else if (rd_addr == 3'd4) m_rd = {1'b0, m_irq, 30'd0};
      else                      m_rd = '0;
      fired = 0;
      if (wr_en && wr_addr == 3'd0) begin
        m_arm = wr_data[31]; m_auto = wr_data[30];
        m_reload = {3'd0, wr_data[28:0]};
        m_left = longint'(m_reload) + 1;
      end else if (m_arm && tick) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          fired = 1;
          if (m_auto) m_left = longint'(m_reload) + 1;
          else m_arm = 0;
        end
      end
      if (fired) m_irq = 1;
      else if (wr_en && wr_addr == 3'd4 && wr_data[30]) m_irq = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (irq !== m_irq || rd_data !== m_rd) begin
        fails++;
        $display("FAIL R3 model compare: irq=%b rd=%h expected irq=%b rd=%h",
                 irq, rd_data, m_irq, m_rd);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    @(posedge clk); @(negedge clk);
    d = rd_data;
  endtask

  // issue ticks separated by gap idle cycles until irq or limit
  task automatic ticks_to_irq(input int gap, input int limit, output int n);
    n = 0;
    while (n < limit) begin
      tick = 1;
      @(posedge clk); @(negedge clk);
      tick = 0;
      n++;
      if (irq) break;
      idle(gap);
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    idle(3);
    rst = 0;
    @(negedge clk);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(3'd0, d); chk("R1 value read", d, 32'd0);
    rd(3'd4, d); chk("R1 irq read", d, 32'd0);

    // single-shot N=3
    wr(3'd0, 32'h8000_0003);
    rd(3'd0, d); chk("R2 readback", d, 32'h8000_0003);
    ticks_to_irq(0, 50, n); chk("R3 ticks N=3", n, 4);
    rd(3'd0, d); chk("R4 arm cleared", d, 32'h0000_0003);
    rd(3'd4, d); chk("R10 irq read", d, 32'h4000_0000);
    rd(3'd6, d); chk("R10 other offset", d, 32'd0);
    wr(3'd4, 32'h4000_0000); chk("R6 cleared", {31'd0, irq}, 32'd0);
    ticks_to_irq(0, 20, n); chk("R4 no refire", {31'd0, irq}, 32'd0);

    // sparse ticks, N=2
    wr(3'd0, 32'h8000_0002);
    ticks_to_irq(2, 50, n); chk("R3 sparse ticks", n, 3);
    idle(10); chk("R6 held", {31'd0, irq}, 32'd1);
    wr(3'd4, 32'h0000_0000); chk("R6 bit30 zero no clear", {31'd0, irq}, 32'd1);
    wr(3'd4, 32'h4000_0000);

    // N=0 with tick during the write cycle ignored
    tick = 1; wr(3'd0, 32'h8000_0000); tick = 0;
    chk("R3 write-cycle tick ignored", {31'd0, irq}, 32'd0);
    ticks_to_irq(0, 10, n); chk("R3 N=0", n, 1);
    wr(3'd4, 32'h4000_0000);

    // auto-reload N=4
    wr(3'd0, 32'hC000_0004);
    ticks_to_irq(0, 50, n); chk("R5 first", n, 5);
    wr(3'd4, 32'h4000_0000);
    ticks_to_irq(1, 50, n); chk("R5 period", n, 5);
    rd(3'd0, d); chk("R5 stays armed", d, 32'hC000_0004);

    // collision: auto N=0 expires every tick
    wr(3'd0, 32'hC000_0000);
    tick = 1; wr(3'd4, 32'h4000_0000); tick = 0;
    chk("R7 expiry beats clear", {31'd0, irq}, 32'd1);

    // stop with zero word; irq unchanged
    wr(3'd0, 32'h0000_0000);
    chk("R8 irq kept", {31'd0, irq}, 32'd1);
    wr(3'd4, 32'h4000_0000);
    ticks_to_irq(0, 20, n); chk("R8 stopped", {31'd0, irq}, 32'd0);

    // restart mid-interval
    wr(3'd0, 32'h8000_000A);
    tick = 1; idle(3); tick = 0;
    wr(3'd0, 32'h8000_0002);
    ticks_to_irq(0, 50, n); chk("R9 restart", n, 3);
    wr(3'd4, 32'h4000_0000);

    // full width field
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R11 max count", d, 32'hDFFF_FFFF);
    wr(3'd0, 32'h0000_0000);
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule